// File: doc/BRIEF.md
# SPI Master Controller with Register Bus

This block is a serial peripheral interface master that a processor drives through a small 32-bit register bus. Software chooses a peripheral through a select field, writes a character into the transmit register, and the block shifts it out MSB first on the serial data output. At the same time it gathers the bits coming back on the serial data input and leaves them in the receive register. Each of the four chip-select lines has its own configuration word: clock idle level, capture edge, character length from 8 to 16 bits, and SCK divider.

Status flags show when received data is waiting, when the transmit register is free, when a received character overwrote one that had not been read, and when the shifter has gone idle. A wait-for-read option holds the next character back until software has read the previous one, so received data is never lost. When a new character is already pending as the current one finishes, the block chains it without releasing the chip select. A software reset bit in the control register clears all of the block's state.

Top module: `spi_host_ctl`

## Requirements
- R1: Register offsets are control 0x00, mode 0x04, receive 0x08, transmit 0x0C, status 0x10, and chip-select config n at 0x30+4n. After reset, status reads 0x0000_0202, mode reads 0x000F_0000, every chip select is high and SCK is low.
- R2: A control write with bit 1 set disables the block. A control write with bit 1 clear and bit 0 set enables it. Status bit 16 shows the enable state. A character starts only when the block is enabled and mode bit 0 (master) is set.
- R3: A control write with bit 7 set returns every register, flag and pending character to its reset value.
- R4: Mode bits 19:16 choose the peripheral. The lowest-numbered bit that is 0 selects that chip-select output, which is driven low during the transfer. At most one output is low at a time. If all four bits are 1, no transfer starts.
- R5: In a config word, bit 0 sets the SCK idle level. With bit 1 set, MISO is captured on the leading SCK edge (SPI CPHA 0). With bit 1 clear, data changes on the leading edge and MISO is captured on the trailing edge (CPHA 1).
- R6: Config bits 7:4 give the character length: value n gives 8+n bits, and values above 8 give 16 bits. Data is right-justified in the transmit and receive registers and is shifted MSB first. Each character gives exactly that many leading SCK edges.
- R7: Config bits 15:8 hold the divider d. The SCK period is d system clocks, with a minimum of 2. A divider of 0 never starts a transfer.
- R8: Status bit 0 sets when a character has been received. A read of the receive register clears it.
- R9: Status bit 1 is 1 while no transmit character is pending. Status bit 9 is 1 only when no character is pending and the shifter is idle.
- R10: Status bit 3 sets when a character completes while status bit 0 is already set. A read of the receive register clears it, and that read returns the newest character.
- R11: With mode bit 5 set, a pending character does not start while status bit 0 is set. It starts after the receive register is read, and no overrun occurs.
- R12: When the next character is already pending as one finishes, the chip select stays low across both characters and rises once, after the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata after the edge |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS (4) | Active-low chip selects |

## Verification
The bench builds the block with its default of four chip selects. This makes each select line reachable through its own config word, so the bench can show that every line draws its polarity, phase, length and divider from its own register. The stimulus table includes character lengths of 8, 9, 10, 12, 15 and 16 bits, dividers from 1 to 6, and all four clock modes. A bench slave that follows the selected mode returns a known pattern, so the received data confirms both the capture edge and the bit order.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  localparam int BUS_W    = 32;
  localparam int CHAR_MAX = 16;
  localparam int CHAR_MIN = 8;
  localparam int BITS_W   = $clog2(CHAR_MAX + 1);

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_RXD  = 8'h08;
  localparam logic [7:0] OFS_TXD  = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_CFG0 = 8'h30;

  // per-select line setup
  typedef struct packed {
    logic [7:0] div;
    logic [3:0] len;
    logic       lead_cap;   // 1: capture on leading edge
    logic       cpol;
  } chan_cfg_t;

  function automatic logic [BITS_W-1:0] char_bits(input logic [3:0] len);
    if (len > 4'd8) return BITS_W'(CHAR_MAX);
    return BITS_W'(CHAR_MIN) + BITS_W'(len);
  endfunction

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 8,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  output logic                soft_rst,
  output logic                go,
  output logic [CHAR_MAX-1:0] tx_word,
  output chan_cfg_t           cfg,
  output logic [SW-1:0]       sel,
  input  logic                take,
  input  logic                done,
  input  logic                busy,
  input  logic [CHAR_MAX-1:0] rx_word
);

  logic            en_q, master_q, nofault_q, wfr_q;
  logic [NCS-1:0]  pcs_q;
  chan_cfg_t       csr_q [NCS];
  logic            pend_q, rdrf_q, ovr_q;
  logic [CHAR_MAX-1:0] hold_q, rdr_q;
  logic            sel_ok;
  logic            rd_rxd;
  logic [BUS_W-1:0] rd_mux;

  assign soft_rst = wr && (addr == AW'(OFS_CTRL)) && wdata[7];
  assign rd_rxd   = rd && (addr == AW'(OFS_RXD));

  // lowest-numbered zero bit wins
  always_comb begin
    sel    = '0;
    sel_ok = 1'b0;
    for (int i = NCS - 1; i >= 0; i--) begin
      if (!pcs_q[i]) begin
        sel    = SW'(i);
        sel_ok = 1'b1;
      end
    end
  end

  assign cfg     = csr_q[sel];
  assign tx_word = hold_q;
  assign go      = en_q && master_q && pend_q && sel_ok && (cfg.div != 8'd0)
                   && !(wfr_q && (rdrf_q || done));

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(OFS_CTRL): rd_mux = '0;
      AW'(OFS_MODE): rd_mux = (BUS_W'(pcs_q) << 16) | BUS_W'({wfr_q, nofault_q, 3'b000, master_q});
      AW'(OFS_RXD):  rd_mux = BUS_W'(rdr_q);
      AW'(OFS_STAT): rd_mux = (BUS_W'(en_q) << 16) | (BUS_W'(!pend_q && !busy) << 9)
                              | (BUS_W'(ovr_q) << 3) | (BUS_W'(!pend_q) << 1) | BUS_W'(rdrf_q);
      default: begin
        for (int i = 0; i < NCS; i++)
          if (addr == AW'(OFS_CFG0 + 4 * i))
            rd_mux = BUS_W'({csr_q[i].div, csr_q[i].len, 2'b00, csr_q[i].lead_cap, csr_q[i].cpol});
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      en_q      <= 1'b0;
      master_q  <= 1'b0;
      nofault_q <= 1'b0;
      wfr_q     <= 1'b0;
      pcs_q     <= '1;
      for (int i = 0; i < NCS; i++) csr_q[i] <= '0;
      pend_q    <= 1'b0;
      rdrf_q    <= 1'b0;
      ovr_q     <= 1'b0;
      hold_q    <= '0;
      rdr_q     <= '0;
      rdata     <= '0;
    end else begin
      if (wr && addr == AW'(OFS_CTRL)) begin
        if (wdata[1])      en_q <= 1'b0;
        else if (wdata[0]) en_q <= 1'b1;
      end
      if (wr && addr == AW'(OFS_MODE)) begin
        master_q  <= wdata[0];
        nofault_q <= wdata[4];
        wfr_q     <= wdata[5];
        pcs_q     <= wdata[16 +: NCS];
      end
      for (int i = 0; i < NCS; i++) begin
        if (wr && addr == AW'(OFS_CFG0 + 4 * i)) begin
          csr_q[i].cpol     <= wdata[0];
          csr_q[i].lead_cap <= wdata[1];
          csr_q[i].len      <= wdata[7:4];
          csr_q[i].div      <= wdata[15:8];
        end
      end
      if (take) pend_q <= 1'b0;
      if (wr && addr == AW'(OFS_TXD)) begin
        hold_q <= wdata[CHAR_MAX-1:0];
        pend_q <= 1'b1;
      end
      if (rd_rxd) begin
        rdrf_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (done) begin
        rdr_q  <= rx_word;
        rdrf_q <= 1'b1;
        if (rdrf_q && !rd_rxd) ovr_q <= 1'b1;
      end
      if (rd) rdata <= rd_mux;
    end
  end

  a_r11_hold_when_full: assert property (@(posedge clk) disable iff (rst)
    (wfr_q && rdrf_q) |-> !take);
  a_r10_ovr_from_full: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $past(rdrf_q));
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_rxd && !done && !soft_rst) |=> !rdrf_q);
  a_r7_no_zero_div: assert property (@(posedge clk) disable iff (rst)
    take |-> (cfg.div != 8'd0));

endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
  import spi_host_pkg::*;
#(
  parameter int NCS = 4,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  chan_cfg_t           cfg,
  input  logic [SW-1:0]       sel,
  input  logic [CHAR_MAX-1:0] tx_word,
  output logic                take,
  output logic                done,
  output logic                busy,
  output logic [CHAR_MAX-1:0] rx_word,
  output logic                sck,
  output logic                mosi,
  output logic [NCS-1:0]      cs_n,
  input  logic                miso
);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_TRAIL} st_t;

  st_t                 state;
  logic [7:0]          cnt, dv;
  logic                cpol_q, lead_q;
  logic [BITS_W-1:0]   nb, bitn, nb_new;
  logic [CHAR_MAX-1:0] sreg, rreg, tx_al;
  logic                last;

  function automatic logic [7:0] half_a(input logic [7:0] d);
    return d - (d >> 1);
  endfunction

  function automatic logic [7:0] half_b(input logic [7:0] d);
    return ((d >> 1) == 8'd0) ? 8'd1 : (d >> 1);
  endfunction

  assign nb_new  = char_bits(cfg.len);
  assign tx_al   = tx_word << (CHAR_MAX - int'(nb_new));
  assign last    = (bitn == nb - 1'b1);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_TRAIL) && (cnt == 8'd1) && last;
  assign take    = go && ((state == S_IDLE) || done);
  assign rx_word = lead_q ? rreg : {rreg[CHAR_MAX-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      dv     <= '0;
      cpol_q <= 1'b0;
      lead_q <= 1'b0;
      nb     <= BITS_W'(CHAR_MIN);
      bitn   <= '0;
      sreg   <= '0;
      rreg   <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      cs_n   <= '1;
    end else if (take) begin
      state  <= S_LEAD;
      cnt    <= half_a(cfg.div);
      dv     <= cfg.div;
      cpol_q <= cfg.cpol;
      lead_q <= cfg.lead_cap;
      nb     <= nb_new;
      bitn   <= '0;
      sreg   <= tx_al;
      rreg   <= '0;
      mosi   <= tx_al[CHAR_MAX-1];
      sck    <= cfg.cpol;
      cs_n   <= ~(NCS'(1) << sel);
    end else begin
      case (state)
        S_IDLE: begin
          sck  <= cfg.cpol;
          cs_n <= '1;
        end
        S_LEAD: begin
          if (cnt == 8'd1) begin
            state <= S_TRAIL;
            cnt   <= half_b(dv);
            sck   <= ~cpol_q;
            if (lead_q) rreg <= {rreg[CHAR_MAX-2:0], miso};
            else        mosi <= sreg[CHAR_MAX-1];
          end else begin
            cnt <= cnt - 8'd1;
          end
        end
        S_TRAIL: begin
          if (cnt == 8'd1) begin
            sck  <= cpol_q;
            sreg <= sreg << 1;
            if (!lead_q) rreg <= {rreg[CHAR_MAX-2:0], miso};
            if (last) begin
              state <= S_IDLE;
            end else begin
              bitn  <= bitn + 1'b1;
              state <= S_LEAD;
              cnt   <= half_a(dv);
              if (lead_q) mosi <= sreg[CHAR_MAX-2];
            end
          end else begin
            cnt <= cnt - 8'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n));
  a_r4_busy_selected: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cs_n != '1));
  a_r6_bit_range: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bitn < nb));
  a_r7_sck_steady: assert property (@(posedge clk) disable iff (rst)
    (state == S_LEAD && cnt != 8'd1) |=> $stable(sck));

endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_host_pkg::*;
#(
  parameter int NCS = 4,
  localparam int SW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic [NCS-1:0]   spi_cs_n
);

  logic                soft_rst, go, take, done, busy;
  logic [CHAR_MAX-1:0] tx_word, rx_word;
  chan_cfg_t           cfg;
  logic [SW-1:0]       sel;

  spi_host_regs #(.NCS(NCS), .AW(8)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .soft_rst(soft_rst),
    .go      (go),
    .tx_word (tx_word),
    .cfg     (cfg),
    .sel     (sel),
    .take    (take),
    .done    (done),
    .busy    (busy),
    .rx_word (rx_word)
  );

  spi_host_shift #(.NCS(NCS)) u_shift (
    .clk    (clk),
    .rst    (rst || soft_rst),
    .go     (go),
    .cfg    (cfg),
    .sel    (sel),
    .tx_word(tx_word),
    .take   (take),
    .done   (done),
    .busy   (busy),
    .rx_word(rx_word),
    .sck    (spi_sck),
    .mosi   (spi_mosi),
    .cs_n   (spi_cs_n),
    .miso   (spi_miso)
  );

endmodule

// File: tb/test_spi_host_ctl.sv
module test_spi_host_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi;
  logic        s_miso = 1'b0;
  logic [3:0]  spi_cs_n;

  always #2 clk = ~clk;  // 250 MHz

  spi_host_ctl i_spi_host_ctl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(s_miso), .spi_cs_n(spi_cs_n)
  );

  int total = 0, bad = 0;

  // slave model driven by the selected mode
  logic        m_cpol = 0, m_lead = 1;
  int          m_len = 8;
  logic [15:0] m_word = '0;
  logic [15:0] s_rx = '0;
  int          s_idx = 0;
  logic        cs_act;
  assign cs_act = (spi_cs_n != 4'hF);

  always @(posedge cs_act) begin
    s_idx = 0;
    if (m_lead) s_miso = m_word[m_len-1];
  end

  always @(spi_sck) begin
    if (cs_act === 1'b1) begin
      if (spi_sck == ~m_cpol) begin
        if (m_lead) s_rx = {s_rx[14:0], spi_mosi};
        else begin
          s_miso = m_word[m_len-1-s_idx];
          s_idx = (s_idx + 1) % m_len;
        end
      end else begin
        if (m_lead) begin
          s_idx = (s_idx + 1) % m_len;
          s_miso = m_word[m_len-1-s_idx];
        end else s_rx = {s_rx[14:0], spi_mosi};
      end
    end
  end

  // line monitor
  int   cyc = 0, n_lead = 0, lead_c0 = 0, lead_c1 = 0, cs_rises = 0;
  logic [3:0] cs_seen = '0;
  logic p_sck = 0, p_act = 0;
  always @(negedge clk) begin
    cyc++;
    if (cs_act === 1'b1) begin
      cs_seen |= ~spi_cs_n;
      if (spi_sck !== p_sck && spi_sck == ~m_cpol) begin
        if (n_lead == 0) lead_c0 = cyc;
        if (n_lead == 1) lead_c1 = cyc;
        n_lead++;
      end
    end
    if (p_act === 1'b1 && cs_act === 1'b0) cs_rises++;
    p_sck = spi_sck;
    p_act = cs_act;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int k = 0; k < 2000; k++) begin
      rd_reg(8'h10, st);
      if (st[9]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clr_mon();
    n_lead = 0; cs_seen = '0; cs_rises = 0; s_rx = '0;
  endtask

  function automatic logic [31:0] cfg_word(input logic cpol, input logic lead,
                                           input logic [3:0] len, input logic [7:0] div);
    return {16'h0, div, len, 2'b00, lead, cpol};
  endfunction

  // {cs, cpol, lead, len, div, tx, slave word}
  localparam logic [47:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b1, 4'd0, 8'd4, 16'h00A5, 16'h003C},
    {2'd1, 1'b1, 1'b1, 4'd8, 8'd2, 16'hBEEF, 16'h8001},
    {2'd2, 1'b0, 1'b0, 4'd4, 8'd5, 16'h0ABC, 16'h0F0F},
    {2'd3, 1'b1, 1'b0, 4'd1, 8'd3, 16'h0155, 16'h00AA},
    {2'd0, 1'b1, 1'b1, 4'd7, 8'd1, 16'h7ACE, 16'h4321},
    {2'd1, 1'b0, 1'b0, 4'd2, 8'd6, 16'h02C3, 16'h0135}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h10, r); chk("R1 status after reset", r, 32'h0000_0202);
    rd_reg(8'h04, r); chk("R1 mode after reset", r, 32'h000F_0000);
    chk("R1 cs idle", {28'h0, spi_cs_n}, 32'hF);
    chk("R1 sck idle", {31'h0, spi_sck}, 32'h0);

    // table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      logic [1:0]  cs;
      logic        cp, ld;
      logic [3:0]  ln;
      logic [7:0]  dv;
      logic [15:0] tx, sw, mask;
      int          nb, per;
      {cs, cp, ld, ln, dv, tx, sw} = VEC[v];
      nb   = (ln > 8) ? 16 : 8 + int'(ln);
      mask = 16'((32'h1 << nb) - 1);
      per  = (dv < 2) ? 2 : int'(dv);
      wr_reg(8'h30 + 8'(4 * cs), cfg_word(cp, ld, ln, dv));
      wr_reg(8'h04, (32'(~(4'b1 << cs)) << 16) | 32'h1);
      wr_reg(8'h00, 32'h1);
      m_cpol = cp; m_lead = ld; m_len = nb; m_word = sw;
      repeat (4) @(negedge clk);
      chk("R5 idle level", {31'h0, spi_sck}, {31'h0, cp});
      clr_mon();
      wr_reg(8'h0C, {16'h0, tx});
      wait_idle();
      chk("R4 select line", {28'h0, cs_seen}, {28'h0, 4'b1 << cs});
      chk("R6 edge count", n_lead, nb);
      chk("R7 sck period", lead_c1 - lead_c0, per);
      chk("R6 mosi data", {16'h0, s_rx & mask}, {16'h0, tx & mask});
      rd_reg(8'h10, r); chk("R8 full flag set", r & 32'h1, 32'h1);
      rd_reg(8'h08, r); chk("R5 miso data", r, {16'h0, sw & mask});
      rd_reg(8'h10, r); chk("R8 full flag clear", r & 32'h1, 32'h0);
      chk("R5 idle after", {31'h0, spi_sck}, {31'h0, cp});
    end

    // R10 overrun
    m_cpol = 0; m_lead = 1; m_len = 8; m_word = 16'h005A;
    wr_reg(8'h30, cfg_word(0, 1, 0, 2));
    wr_reg(8'h04, 32'h000E_0001);
    wr_reg(8'h0C, 32'h11); wait_idle();
    wr_reg(8'h0C, 32'h22); wait_idle();
    rd_reg(8'h10, r); chk("R10 overrun set", r & 32'h9, 32'h9);
    rd_reg(8'h08, r); chk("R10 newest data", r, 32'h5A);
    rd_reg(8'h10, r); chk("R10 overrun clear", r & 32'h9, 32'h0);

    // R12 back-to-back
    clr_mon();
    wr_reg(8'h0C, 32'h33);
    for (int k = 0; k < 200; k++) begin
      rd_reg(8'h10, r);
      if (r[1]) break;
    end
    wr_reg(8'h0C, 32'h44);
    wait_idle();
    chk("R12 single cs release", cs_rises, 1);
    chk("R12 both chars clocked", n_lead, 16);
    rd_reg(8'h08, r);

    // R11 wait-for-read
    wr_reg(8'h04, 32'h000E_0021);
    clr_mon();
    wr_reg(8'h0C, 32'h55); wait_idle();
    wr_reg(8'h0C, 32'h66);
    repeat (60) @(negedge clk);
    rd_reg(8'h10, r); chk("R11 held while full", r & 32'h20B, 32'h001);
    chk("R11 one char only", n_lead, 8);
    rd_reg(8'h08, r);
    wait_idle();
    rd_reg(8'h10, r); chk("R11 no overrun", r & 32'h209, 32'h201);
    chk("R11 second char ran", n_lead, 16);
    rd_reg(8'h08, r);

    // R2 disable
    wr_reg(8'h04, 32'h000E_0001);
    wr_reg(8'h00, 32'h3);
    rd_reg(8'h10, r); chk("R2 enable flag off", r & 32'h1_0000, 32'h0);
    clr_mon();
    wr_reg(8'h0C, 32'h77);
    repeat (40) @(negedge clk);
    chk("R2 no transfer disabled", n_lead, 0);
    rd_reg(8'h10, r); chk("R9 pending not empty", r & 32'h202, 32'h0);
    wr_reg(8'h00, 32'h1);
    wait_idle();
    chk("R2 runs after enable", n_lead, 8);
    rd_reg(8'h10, r); chk("R2 enable flag on", r & 32'h1_0000, 32'h1_0000);
    rd_reg(8'h08, r);

    // R2 master bit clear, then R4 nothing selected
    wr_reg(8'h04, 32'h000E_0000);
    clr_mon();
    wr_reg(8'h0C, 32'h88);
    repeat (40) @(negedge clk);
    chk("R2 no transfer slave", n_lead, 0);
    wr_reg(8'h04, 32'h000F_0001);
    repeat (40) @(negedge clk);
    chk("R4 no select no transfer", {28'h0, cs_seen}, 32'h0);

    // R7 divider zero
    wr_reg(8'h34, cfg_word(0, 1, 0, 0));
    wr_reg(8'h04, 32'h000D_0001);
    repeat (40) @(negedge clk);
    chk("R7 zero divider idle", {28'h0, cs_seen}, 32'h0);
    rd_reg(8'h10, r); chk("R7 still pending", r & 32'h202, 32'h0);

    // R3 soft reset
    wr_reg(8'h00, 32'h80);
    rd_reg(8'h10, r); chk("R3 status reset", r, 32'h0000_0202);
    rd_reg(8'h34, r); chk("R3 config reset", r, 32'h0);
    rd_reg(8'h04, r); chk("R3 mode reset", r, 32'h000F_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule